// File: doc/BRIEF.md
# Serial Voice-Sample Port with Transparent Forwarding

This block connects internal parallel logic to a serial voice-sample link that is paced by an external bit clock and framed by an external sync pulse. Both serial controls and both serial data inputs pass through a two-flop synchronizer into the internal clock domain. All edges are detected there, so the internal clock must run several times faster than the bit clock. In normal mode the port receives and sends 8-bit samples, most significant bit first. A received sample reaches the internal side as a parallel word with a one-cycle strobe. A parallel transmit word is captured when a frame starts and is shifted out.

A per-port pass-through control switches to 4-bit words. In that mode nothing goes to the internal side. Each 4-bit word received on the selected input is sent back out, unchanged, during the next pass-through frame. It leaves on the primary output when the select is 0 and on the secondary output when the select is 1. Each output has its own drive-enable. The enable is low whenever no active data bit is being driven, so the pin can be treated as high-impedance.

Top module: `pcm_bypass_port`

## Requirements
- R1: With `cfg_thru`=0 and `cfg_tx_en`=1, a frame drives the 8 bits of the transmit word on `ser_out_a`, most significant bit first, one bit per `ser_clk` period, with each bit launched after the `ser_clk` rising edge.
- R2: With `cfg_thru`=0, 8 bits sampled at `ser_clk` falling edges, most significant bit first, form `rx_word`, and `rx_strobe` is high for exactly one `clk` cycle per completed word.
- R3: Both drive-enables are 0 while `rst_n` is low, and become 0 from the first bit period after the last bit of a word.
- R4: With `cfg_thru`=0 and `cfg_tx_en`=0, `ser_out_a_oe` stays 0 for the whole frame, and reception still completes.
- R5: With `cfg_alt_sel`=1 the received bits come from `ser_in_sec`. With `cfg_alt_sel`=0, `ser_in_sec` has no effect on the received word.
- R6: With `cfg_thru`=1 a word is 4 bits long and no `rx_strobe` is produced. The 4-bit word received in one pass-through frame is transmitted in the next pass-through frame, on `ser_out_a` when `cfg_alt_sel`=0 and on `ser_out_b` when it is 1. The forwarded word after reset is 0.
- R7: Pass-through overrides `cfg_tx_en`: the selected output is driven even when `cfg_tx_en`=0. The two drive-enables are never both 1, and `ser_out_b_oe` stays 0 in normal mode.
- R8: A frame start during a word abandons the partial word (no strobe) and restarts at the most significant bit with a newly captured transmit word.
- R9: `tx_word` is captured at the frame start; changing it later in the frame does not alter the bits sent.
- R10: A frame starts only on a 0-to-1 change of `ser_sync` seen at a `ser_clk` rising edge. Holding `ser_sync` high for several bits starts just one frame. The mode inputs are sampled at the frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | External serial bit clock |
| ser_sync | input | 1 | External frame sync |
| ser_in_pri | input | 1 | Primary serial data input |
| ser_in_sec | input | 1 | Secondary serial data input |
| cfg_thru | input | 1 | Pass-through mode (4-bit forwarding) |
| cfg_alt_sel | input | 1 | Selects the secondary input, and the secondary output in pass-through |
| cfg_tx_en | input | 1 | Normal-mode transmit enable |
| tx_word | input | 8 | Parallel transmit sample |
| rx_word | output | 8 | Parallel received sample |
| rx_strobe | output | 1 | One-cycle valid for `rx_word` |
| ser_out_a | output | 1 | Primary serial output data |
| ser_out_a_oe | output | 1 | Primary output drive-enable (0 = high-impedance) |
| ser_out_b | output | 1 | Secondary serial output data |
| ser_out_b_oe | output | 1 | Secondary output drive-enable (0 = high-impedance) |

## Verification
On every cycle, the assertions check that the bit counter stays within the 4-bit word in pass-through, that the strobe never lasts two cycles and never appears in pass-through, and that the transmit shifter moves only on a bit-clock rise. They also check that a detected sync edge restarts the word and that the two outputs are never enabled together. Only the bench scenarios can show the end-to-end serial values. These include the one-frame delay of forwarded words, the routing chosen by the select bit, the capture of the transmit word at frame start, the behaviour of a held sync level and of a mid-word restart, and the silence of the outputs during reset.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
    typedef struct packed {
        logic thru;
        logic alt;
        logic tx_en;
    } pcm_cfg_t;
endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            stg_d[k] = stg_q[k-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/pcm_framer.sv
module pcm_framer
    import pcm_port_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int THRU_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_s,
    input  logic              fs_s,
    input  logic              pri_s,
    input  logic              sec_s,
    input  pcm_cfg_t          cfg,
    input  logic [WORD_W-1:0] tx_word,
    output logic              active,
    output pcm_cfg_t          mode,
    output logic              tx_bit,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_strobe
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam int PAD_W = WORD_W - THRU_W;

    typedef struct packed {
        logic              bclk_last;
        logic              fs_last;
        logic              active;
        logic [CNT_W-1:0]  cnt;
        pcm_cfg_t          mode;
        logic [WORD_W-1:0] tx_sh;
        logic [WORD_W-1:0] rx_sh;
        logic [THRU_W-1:0] fwd;
        logic              strobe;
        logic [WORD_W-1:0] rx_word;
    } frm_st_t;

    frm_st_t st_d, st_q;
    logic rise, fall, start, bit_in;
    logic [CNT_W-1:0]  last_idx;
    logic [WORD_W-1:0] rx_next;

    always_comb begin
        rise     = bclk_s & ~st_q.bclk_last;
        fall     = ~bclk_s & st_q.bclk_last;
        start    = rise & fs_s & ~st_q.fs_last;
        bit_in   = st_q.mode.alt ? sec_s : pri_s;
        last_idx = st_q.mode.thru ? CNT_W'(THRU_W - 1) : CNT_W'(WORD_W - 1);
        rx_next  = {st_q.rx_sh[WORD_W-2:0], bit_in};

        st_d           = st_q;
        st_d.strobe    = 1'b0;
        st_d.bclk_last = bclk_s;

        if (rise) begin
            st_d.fs_last = fs_s;
            if (start) begin
                st_d.active = 1'b1;
                st_d.cnt    = '0;
                st_d.mode   = cfg;
                st_d.tx_sh  = cfg.thru ? {st_q.fwd, {PAD_W{1'b0}}} : tx_word;
            end else if (st_q.active) begin
                if (st_q.cnt == last_idx) begin
                    st_d.active = 1'b0;
                end else begin
                    st_d.cnt   = st_q.cnt + CNT_W'(1);
                    st_d.tx_sh = {st_q.tx_sh[WORD_W-2:0], 1'b0};
                end
            end
        end

        if (fall && st_q.active) begin
            st_d.rx_sh = rx_next;
            if (st_q.cnt == last_idx) begin
                if (st_q.mode.thru) begin
                    st_d.fwd = rx_next[THRU_W-1:0];
                end else begin
                    st_d.strobe  = 1'b1;
                    st_d.rx_word = rx_next;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active    = st_q.active;
    assign mode      = st_q.mode;
    assign tx_bit    = st_q.tx_sh[WORD_W-1];
    assign rx_word   = st_q.rx_word;
    assign rx_strobe = st_q.strobe;

    // Pass-through words never run past the short length
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.mode.thru) |-> (st_q.cnt <= CNT_W'(THRU_W - 1)));
    p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strobe |=> !st_q.strobe);
    p_no_strobe_thru_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strobe |-> !st_q.mode.thru);
    p_shift_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(st_q.tx_sh));
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.active && st_q.cnt == '0));
endmodule

// File: rtl/pcm_pin_drive.sv
module pcm_pin_drive
    import pcm_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     active,
    input  pcm_cfg_t mode,
    input  logic     tx_bit,
    output logic     out_a,
    output logic     out_a_oe,
    output logic     out_b,
    output logic     out_b_oe
);
    always_comb begin
        out_a    = tx_bit;
        out_b    = tx_bit;
        out_a_oe = 1'b0;
        out_b_oe = 1'b0;
        if (active) begin
            if (mode.thru) begin
                out_a_oe = ~mode.alt;
                out_b_oe = mode.alt;
            end else begin
                out_a_oe = mode.tx_en;
            end
        end
    end

    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_a_oe && out_b_oe));
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> (!out_a_oe && !out_b_oe));
endmodule

// File: rtl/pcm_bypass_port.sv
module pcm_bypass_port
    import pcm_port_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int THRU_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_sync,
    input  logic              ser_in_pri,
    input  logic              ser_in_sec,
    input  logic              cfg_thru,
    input  logic              cfg_alt_sel,
    input  logic              cfg_tx_en,
    input  logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_strobe,
    output logic              ser_out_a,
    output logic              ser_out_a_oe,
    output logic              ser_out_b,
    output logic              ser_out_b_oe
);
    logic [3:0] raw_in, syn_in;
    logic       active, tx_bit;
    pcm_cfg_t   cfg_in, mode;

    assign raw_in = {ser_in_sec, ser_in_pri, ser_sync, ser_clk};
    assign cfg_in = '{thru: cfg_thru, alt: cfg_alt_sel, tx_en: cfg_tx_en};

    pcm_in_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw_in), .dout(syn_in)
    );

    pcm_framer #(.WORD_W(WORD_W), .THRU_W(THRU_W)) u_framer (
        .clk(clk), .rst_n(rst_n),
        .bclk_s(syn_in[0]), .fs_s(syn_in[1]), .pri_s(syn_in[2]), .sec_s(syn_in[3]),
        .cfg(cfg_in), .tx_word(tx_word),
        .active(active), .mode(mode), .tx_bit(tx_bit),
        .rx_word(rx_word), .rx_strobe(rx_strobe)
    );

    pcm_pin_drive u_drive (
        .clk(clk), .rst_n(rst_n), .active(active), .mode(mode), .tx_bit(tx_bit),
        .out_a(ser_out_a), .out_a_oe(ser_out_a_oe),
        .out_b(ser_out_b), .out_b_oe(ser_out_b_oe)
    );
endmodule

// File: tb/pcm_bypass_port_bench.sv
module pcm_bypass_port_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_sync = 1'b0, ser_in_pri = 1'b0, ser_in_sec = 1'b0;
    logic cfg_thru = 1'b0, cfg_alt_sel = 1'b0, cfg_tx_en = 1'b0;
    logic [7:0] tx_word = 8'h00;
    logic [7:0] rx_word;
    logic rx_strobe, ser_out_a, ser_out_a_oe, ser_out_b, ser_out_b_oe;

    int checks = 0, errs = 0, stb_cnt = 0;
    logic [7:0] stb_word = 8'h00;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pcm_bypass_port u_pcm_bypass_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sync(ser_sync),
        .ser_in_pri(ser_in_pri), .ser_in_sec(ser_in_sec),
        .cfg_thru(cfg_thru), .cfg_alt_sel(cfg_alt_sel), .cfg_tx_en(cfg_tx_en),
        .tx_word(tx_word), .rx_word(rx_word), .rx_strobe(rx_strobe),
        .ser_out_a(ser_out_a), .ser_out_a_oe(ser_out_a_oe),
        .ser_out_b(ser_out_b), .ser_out_b_oe(ser_out_b_oe)
    );

    always @(negedge clk) begin
        if (rx_strobe) begin
            stb_cnt++;
            stb_word = rx_word;
        end
    end

    // thru sel en hold | tx | rx_pri | rx_sec | pin(0 none,1 a,2 b) | exp_out | exp_strobe | exp_rx
    localparam int NV = 9;
    localparam logic [46:0] VEC [NV] = '{
        {1'b0,1'b0,1'b1,1'b0, 8'hA5, 8'h3C, 8'h00, 2'd1, 8'hA5, 1'b1, 8'h3C},
        {1'b0,1'b0,1'b0,1'b0, 8'hFF, 8'h81, 8'h00, 2'd0, 8'h00, 1'b1, 8'h81},
        {1'b0,1'b1,1'b1,1'b0, 8'h5A, 8'h3C, 8'hC3, 2'd1, 8'h5A, 1'b1, 8'hC3},
        {1'b0,1'b0,1'b1,1'b0, 8'h0F, 8'h96, 8'h69, 2'd1, 8'h0F, 1'b1, 8'h96},
        {1'b1,1'b0,1'b1,1'b0, 8'h77, 8'hB0, 8'h00, 2'd1, 8'h00, 1'b0, 8'h00},
        {1'b1,1'b0,1'b0,1'b0, 8'h77, 8'h60, 8'hF0, 2'd1, 8'hB0, 1'b0, 8'h00},
        {1'b1,1'b1,1'b1,1'b0, 8'h77, 8'h50, 8'hD0, 2'd2, 8'h60, 1'b0, 8'h00},
        {1'b1,1'b0,1'b1,1'b0, 8'h00, 8'h00, 8'h00, 2'd1, 8'hD0, 1'b0, 8'h00},
        {1'b0,1'b0,1'b1,1'b1, 8'hC3, 8'h5A, 8'h00, 2'd1, 8'hC3, 1'b1, 8'h5A}
    };

    function automatic string vec_tag(int idx);
        case (idx)
            0: return "R1 R2 R9";
            1: return "R4";
            2: return "R5";
            3: return "R5";
            4: return "R6";
            5: return "R7";
            6: return "R6";
            7: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One bit period: 16 clk cycles, outputs sampled late in the low phase
    task automatic one_bit(input logic fs, input logic dp, input logic ds,
                           output logic oa, output logic da,
                           output logic ob, output logic db);
        ser_clk = 1'b1; ser_sync = fs; ser_in_pri = dp; ser_in_sec = ds;
        repeat (8) @(negedge clk);
        ser_clk = 1'b0;
        repeat (6) @(negedge clk);
        oa = ser_out_a_oe; da = ser_out_a; ob = ser_out_b_oe; db = ser_out_b;
        repeat (2) @(negedge clk);
    endtask

    task automatic frame(input logic [46:0] v, input string tag);
        logic thru, sel, en, hold;
        logic [7:0] tx, rp, rs, eo, erx;
        logic [1:0] pin;
        logic estb;
        logic [9:0] oa, da, ob, db, ea, eb, ed;
        int len;
        {thru, sel, en, hold, tx, rp, rs, pin, eo, estb, erx} = v;
        cfg_thru = thru; cfg_alt_sel = sel; cfg_tx_en = en; tx_word = tx;
        stb_cnt = 0;
        len = thru ? 4 : 8;
        for (int i = 0; i < 10; i++) begin
            one_bit((i == 0) || (hold && i < 8),
                    (i < 8) ? rp[7-i] : 1'b0, (i < 8) ? rs[7-i] : 1'b0,
                    oa[i], da[i], ob[i], db[i]);
            if (i == 0) tx_word = ~tx;   // R9: later changes must not matter
        end
        for (int i = 0; i < 10; i++) begin
            ea[i] = (pin == 2'd1) && (i < len);
            eb[i] = (pin == 2'd2) && (i < len);
            ed[i] = (i < 8) ? eo[7-i] : 1'b0;
        end
        chk(oa == ea && (da & ea) == (ed & ea), tag, "out_a oe/data",
            {12'h0, oa, da}, {12'h0, ea, ed & ea});
        chk(ob == eb && (db & eb) == (ed & eb), tag, "out_b oe/data",
            {12'h0, ob, db}, {12'h0, eb, ed & eb});
        chk(stb_cnt == int'(estb) && (!estb || stb_word == erx), tag, "rx strobe/word",
            {stb_cnt[23:0], stb_word}, {23'h0, estb, erx});
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic oa, da, ob, db;
        bit seen;
        // R3: reset keeps outputs quiet even with active framing
        cfg_tx_en = 1'b1; tx_word = 8'hFF;
        seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            one_bit(i == 0, 1'b1, 1'b1, oa, da, ob, db);
            if (oa || ob || rx_strobe) seen = 1'b1;
        end
        chk(!seen, "R3", "enables during reset", {31'h0, seen}, 32'h0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!ser_out_a_oe && !ser_out_b_oe && !rx_strobe, "R3", "after reset",
            {29'h0, ser_out_a_oe, ser_out_b_oe, rx_strobe}, 32'h0);
        for (int i = 0; i < 2; i++) one_bit(1'b0, 1'b0, 1'b0, oa, da, ob, db);

        for (int k = 0; k < NV; k++) frame(VEC[k], vec_tag(k));

        // R8: sync restart after three bits of a word
        cfg_thru = 1'b0; cfg_alt_sel = 1'b0; cfg_tx_en = 1'b1; tx_word = 8'hA5;
        stb_cnt = 0;
        for (int i = 0; i < 3; i++) one_bit(i == 0, 1'b1, 1'b0, oa, da, ob, db);
        chk(stb_cnt == 0, "R8", "no strobe for partial word", stb_cnt, 32'h0);
        frame({1'b0,1'b0,1'b1,1'b0, 8'h3C, 8'hE7, 8'h00, 2'd1, 8'h3C, 1'b1, 8'hE7}, "R8");

        // R3: enables drop once the word has ended
        repeat (4) @(negedge clk);
        chk(!ser_out_a_oe && !ser_out_b_oe, "R3", "idle after word",
            {30'h0, ser_out_a_oe, ser_out_b_oe}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule